// File: doc/BRIEF.md
# Receive FIFO Character Timeout Detector

This block sits beside the receive FIFO of a UART. It raises a pending flag when characters have been left unread for too long, so that the host can collect a short final burst that never reached the FIFO trigger level. The block counts bit-time ticks from the baud generator. The count stops and returns to zero when the FIFO is empty or the receive interrupt is disabled. It also restarts whenever a character is pushed into the FIFO or the host pops one. The flag is set once more than four whole character times have passed since the last restart.

A character time is the full serial frame: one start bit, five to eight data bits, an optional parity bit and one or two stop bits. When two stop bits are selected, both are counted. For a 12-bit frame at 300 baud, four character times are 48 bit times, or 160 ms. The flag fires on the first tick after that. The flag feeds the interrupt identification logic. In polled mode (interrupt disabled) the FIFO keeps working and this block stays silent.

The asynchronous reset input is synchronised inside the block before it reaches the registers. Assertion is immediate and release takes two clock edges.

Top module: `rx_timeout_det`

## Requirements
- R1: After reset, `timeout_pend` is 0.
- R2: If `rx_level` is 0 in a cycle, `timeout_pend` is 0 after the next clock edge.
- R3: With data present, the receive interrupt enabled and no push or pop, `timeout_pend` rises on the clock edge that samples the (4·F+1)-th `bit_tick` since the last restart. F is the frame length in bits.
- R4: An `rx_push` restarts the count from zero. Ticks seen before the push do not count towards the timeout.
- R5: An `rx_pop` clears `timeout_pend` at the next edge and restarts the count from zero.
- R6: F = 1 + (5 + `data_len`) + `parity_en` + (`two_stop` ? 2 : 1). The `data_len` encoding is 0 to 3 for 5 to 8 data bits.
- R7: While `rx_int_en` is 0, `timeout_pend` is 0 after the next edge and the count is held at zero. After the interrupt is enabled again, a full 4·F+1 ticks are needed.
- R8: Once set, `timeout_pend` stays high until a pop, an empty FIFO or a disable. Further ticks do not clear it, and neither does a push.
- R9: Ticks that arrive while the FIFO is empty are not counted. After data arrives, a full 4·F+1 ticks are needed.
- R10: A `bit_tick` sampled in the same cycle as an `rx_push` or `rx_pop` is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle pulse per serial bit time |
| rx_push | input | 1 | A character was written into the receive FIFO |
| rx_pop | input | 1 | The host read one character from the receive FIFO |
| rx_level | input | LVL_W | Receive FIFO occupancy |
| rx_int_en | input | 1 | Receive interrupt enable; 0 selects polled mode |
| data_len | input | 2 | Data bits minus five |
| parity_en | input | 1 | A parity bit is present in the frame |
| two_stop | input | 1 | Two stop bits are present in the frame |
| timeout_pend | output | 1 | Character timeout pending |

## Verification
The assertions check on every cycle that the flag drops after an empty FIFO, a disable or a pop. They also check that, once set, it holds while none of those occur. A further check is that it only ever rises on an edge that sampled a tick with no push or pop in the same cycle. The exact tick count that makes the flag fire, how that count depends on the frame configuration, and the restarts after a push, a pop, an empty period or a disabled period are shown only by the bench's scenarios and its cycle-accurate reference model.

// File: rtl/rxto_pkg.sv
package rxto_pkg;

  localparam int START_BITS = 1;
  localparam int MIN_DATA   = 5;
  localparam int MAX_FRAME  = 12;

  typedef struct packed {
    logic [1:0] data_len;
    logic       parity_en;
    logic       two_stop;
  } frame_cfg_t;

  function automatic logic [3:0] frame_bits(input frame_cfg_t c);
    logic [3:0] n;
    n = 4'(START_BITS + MIN_DATA) + {2'b00, c.data_len};
    n = n + {3'b000, c.parity_en};
    n = n + (c.two_stop ? 4'd2 : 4'd1);
    return n;
  endfunction

endpackage

// File: rtl/rxto_rst_sync.sv
module rxto_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_n_sync = stage_q[1];

endmodule

// File: rtl/rxto_frame_len.sv
module rxto_frame_len
  import rxto_pkg::*;
#(
  parameter int CHAR_TIMES = 4,
  parameter int CNT_W      = 6
) (
  input  frame_cfg_t       cfg,
  output logic [CNT_W-1:0] limit
);

  logic [3:0]       fbits;
  logic [CNT_W+3:0] prod;

  always_comb begin
    fbits = frame_bits(cfg);
    prod  = (CNT_W+4)'(CHAR_TIMES) * {{CNT_W{1'b0}}, fbits};
    limit = CNT_W'(prod + 1'b1);
  end

endmodule

// File: rtl/rxto_char_timer.sv
module rxto_char_timer #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             restart,
  input  logic             hold,
  input  logic [CNT_W-1:0] limit,
  output logic             hit
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;
  logic [CNT_W:0]   cnt_inc;
  logic             at_lim;

  always_comb begin
    cnt_inc = {1'b0, cnt_q} + 1'b1;
    at_lim  = (cnt_q >= limit);
    hit     = tick && !restart && !hold && (cnt_inc >= {1'b0, limit});
    cnt_en  = restart || hold || (tick && !at_lim);
    if (restart || hold) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_inc[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/rxto_pend_flag.sv
module rxto_pend_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic pend
);

  logic pend_q;
  logic pend_d;

  always_comb begin
    if (clr) begin
      pend_d = 1'b0;
    end else if (set) begin
      pend_d = 1'b1;
    end else begin
      pend_d = pend_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
    end
  end

  assign pend = pend_q;

endmodule

// File: rtl/rx_timeout_det.sv
module rx_timeout_det
  import rxto_pkg::*;
#(
  parameter int LVL_W      = 6,
  parameter int CHAR_TIMES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_tick,
  input  logic             rx_push,
  input  logic             rx_pop,
  input  logic [LVL_W-1:0] rx_level,
  input  logic             rx_int_en,
  input  logic [1:0]       data_len,
  input  logic             parity_en,
  input  logic             two_stop,
  output logic             timeout_pend
);

  localparam int CNT_W = $clog2(CHAR_TIMES * MAX_FRAME + 2);

  logic             rst_n_int;
  frame_cfg_t       cfg;
  logic [CNT_W-1:0] limit;
  logic             fifo_empty;
  logic             quiet;
  logic             restart;
  logic             hit;

  always_comb begin
    cfg.data_len  = data_len;
    cfg.parity_en = parity_en;
    cfg.two_stop  = two_stop;
    fifo_empty    = (rx_level == '0);
    quiet         = fifo_empty || !rx_int_en;
    restart       = rx_push || rx_pop;
  end

  rxto_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  rxto_frame_len #(
    .CHAR_TIMES (CHAR_TIMES),
    .CNT_W      (CNT_W)
  ) u_len (
    .cfg   (cfg),
    .limit (limit)
  );

  rxto_char_timer #(
    .CNT_W (CNT_W)
  ) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .tick    (bit_tick),
    .restart (restart),
    .hold    (quiet),
    .limit   (limit),
    .hit     (hit)
  );

  rxto_pend_flag u_flag (
    .clk   (clk),
    .rst_n (rst_n_int),
    .set   (hit),
    .clr   (quiet || rx_pop),
    .pend  (timeout_pend)
  );

endmodule

// File: rtl/rx_timeout_chk.sv
module rx_timeout_chk #(
  parameter int LVL_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bit_tick,
  input logic             rx_push,
  input logic             rx_pop,
  input logic [LVL_W-1:0] rx_level,
  input logic             rx_int_en,
  input logic             timeout_pend
);

  AST_EMPTY_NO_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_level == '0) |=> !timeout_pend); // R2

  AST_DISABLED_NO_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_int_en |=> !timeout_pend); // R7

  AST_POP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop |=> !timeout_pend); // R5

  AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_pend && rx_int_en && (rx_level != '0) && !rx_pop) |=> timeout_pend); // R8

  AST_RISE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_pend) |-> $past(bit_tick)); // R3

  AST_RISE_NOT_ON_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_pend) |-> (!$past(rx_push) && !$past(rx_pop))); // R10

endmodule

bind rx_timeout_det rx_timeout_chk #(.LVL_W(LVL_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bit_tick     (bit_tick),
  .rx_push      (rx_push),
  .rx_pop       (rx_pop),
  .rx_level     (rx_level),
  .rx_int_en    (rx_int_en),
  .timeout_pend (timeout_pend)
);

// File: tb/tb_rx_timeout_det.sv
module tb_rx_timeout_det;

  localparam int LVL_W = 6;

  logic             clk;
  logic             rst_n;
  logic             bit_tick;
  logic             rx_push;
  logic             rx_pop;
  logic [LVL_W-1:0] rx_level;
  logic             rx_int_en;
  logic [1:0]       data_len;
  logic             parity_en;
  logic             two_stop;
  logic             timeout_pend;

  int    n_tests;
  int    n_fail;
  int    cycles;
  string cur_req;

  int    m_elapsed;
  bit    m_pend;

  rx_timeout_det #(.LVL_W(LVL_W)) dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .bit_tick     (bit_tick),
    .rx_push      (rx_push),
    .rx_pop       (rx_pop),
    .rx_level     (rx_level),
    .rx_int_en    (rx_int_en),
    .data_len     (data_len),
    .parity_en    (parity_en),
    .two_stop     (two_stop),
    .timeout_pend (timeout_pend)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic int frame_len_ref();
    return 1 + 5 + int'(data_len) + int'(parity_en) + (two_stop ? 2 : 1);
  endfunction

  // Behavioural reference model, updated on every edge from the sampled inputs.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_elapsed = 0;
      m_pend    = 1'b0;
    end else begin
      int lim;
      bit idle;
      lim  = 4 * frame_len_ref() + 1;
      idle = !rx_int_en || (rx_level == 0);
      if (idle || rx_pop) m_pend = 1'b0;
      else if (bit_tick && !rx_push && (m_elapsed + 1 >= lim)) m_pend = 1'b1;
      if (idle || rx_push || rx_pop) m_elapsed = 0;
      else if (bit_tick && m_elapsed < lim) m_elapsed = m_elapsed + 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      n_tests++;
      if (timeout_pend !== m_pend) begin
        n_fail++;
        $display("FAIL %s model compare at cycle %0d: actual=%0b expected=%0b",
                 cur_req, cycles, timeout_pend, m_pend);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_fail++;
      $display("FAIL watchdog expired: actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit exp, input string req);
    n_tests++;
    if (timeout_pend !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0b expected=%0b", req, timeout_pend, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); bit_tick = 1'b1;
      @(negedge clk); bit_tick = 1'b0;
    end
  endtask

  task automatic push1(input bit with_tick);
    @(negedge clk); rx_push = 1'b1; bit_tick = with_tick;
    @(negedge clk); rx_push = 1'b0; bit_tick = 1'b0;
  endtask

  task automatic pop1();
    @(negedge clk); rx_pop = 1'b1;
    @(negedge clk); rx_pop = 1'b0;
  endtask

  initial begin
    n_tests = 0; n_fail = 0; cycles = 0; cur_req = "R1";
    rst_n = 1'b0; bit_tick = 1'b0; rx_push = 1'b0; rx_pop = 1'b0;
    rx_level = '0; rx_int_en = 1'b1;
    data_len = 2'd3; parity_en = 1'b0; two_stop = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(1'b0, "R1 reset state");

    // 8N1: F=10, fires on tick 41
    cur_req = "R3";
    rx_level = 6'd1;
    ticks(40); chk(1'b0, "R3 no fire after 40 ticks");
    ticks(1);  chk(1'b1, "R3 fire on tick 41");

    cur_req = "R8";
    ticks(5);  chk(1'b1, "R8 holds under ticks");
    push1(1'b0); chk(1'b1, "R8 push keeps pend");

    cur_req = "R5";
    pop1(); chk(1'b0, "R5 pop clears");
    ticks(40); chk(1'b0, "R5 restart, 40 ticks");
    ticks(1);  chk(1'b1, "R5 restart, fire on 41");

    cur_req = "R4";
    pop1();
    ticks(30);
    push1(1'b0);
    ticks(40); chk(1'b0, "R4 push restarts count");
    ticks(1);  chk(1'b1, "R4 fire 41 after push");

    cur_req = "R2";
    @(negedge clk); rx_level = '0;
    @(negedge clk); chk(1'b0, "R2 empty clears");
    cur_req = "R9";
    ticks(50); chk(1'b0, "R9 ticks while empty");
    @(negedge clk); rx_level = 6'd1;
    ticks(40); chk(1'b0, "R9 full count needed");
    ticks(1);  chk(1'b1, "R9 fire on 41");

    // 5 data, parity, two stop: F=9, fires on tick 37
    cur_req = "R6";
    @(negedge clk); data_len = 2'd0; parity_en = 1'b1; two_stop = 1'b1;
    pop1();
    ticks(36); chk(1'b0, "R6 F=9 36 ticks");
    ticks(1);  chk(1'b1, "R6 F=9 fire on 37");

    // 8 data, parity, two stop: F=12, fires on tick 49
    @(negedge clk); data_len = 2'd3;
    pop1();
    ticks(48); chk(1'b0, "R6 F=12 48 ticks");
    ticks(1);  chk(1'b1, "R6 F=12 fire on 49");

    cur_req = "R7";
    @(negedge clk); rx_int_en = 1'b0;
    @(negedge clk); chk(1'b0, "R7 disable clears");
    ticks(60); chk(1'b0, "R7 silent while disabled");
    @(negedge clk); rx_int_en = 1'b1;
    ticks(48); chk(1'b0, "R7 re-enable 48 ticks");
    ticks(1);  chk(1'b1, "R7 re-enable fire on 49");

    cur_req = "R10";
    pop1();
    push1(1'b1);
    ticks(48); chk(1'b0, "R10 tick with push not counted");
    ticks(1);  chk(1'b1, "R10 fire on 49 after push");

    repeat (3) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule